// File: doc/BRIEF.md
# Serial Receive Buffer with Programmable Fill Threshold

This block holds received bytes for a serial port until the register bank reads them. Bytes from the deserialiser go into a circular store of DEPTH entries. A read-pop strobe removes the oldest byte, and the current occupancy is always visible on an output.

A receive-ready flag rises when the occupancy reaches a threshold that software chooses. It does not wait for the store to become full. When the interrupt enable is high, the same event latches an interrupt line, which stays high until the register bank clears it. A write to the FIFO control register carries the two-bit threshold selector and a flush bit.

Arrivals that find the store full are dropped without any indication. Arrivals are also refused while the receive-enable input is low.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset the occupancy is 0, the receive-ready flag and the interrupt are low, and the threshold is 1 byte.
- R2: Bytes leave in arrival order. `rd_data` shows the oldest stored byte, and a pop on a non-empty store removes it and lowers `level` by one.
- R3: The write and read positions wrap from the last entry back to entry 0, so order is kept over any number of bytes passing through.
- R4: A control write loads bits 7:6 of `cfg_wdata` as the threshold selector. Code 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14.
- R5: An accepted byte that brings `level` to or above the threshold sets `rx_full`. A pop that brings `level` below the threshold clears it.
- R6: The same accepted byte also sets `irq`, but only when `rxie` is high. `irq` then stays high until `irq_clr` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R7: A control write with bit 1 of `cfg_wdata` set empties the store and clears `rx_full`. It overrides a push or a pop in the same cycle.
- R8: A byte that arrives while 16 bytes are held is discarded, and the stored contents and `level` stay unchanged.
- R9: While `rx_en` is low, arriving bytes are ignored.
- R10: A pop on an empty store changes neither `level` nor the read position.
- R11: A push and a pop in the same cycle leave `level` unchanged and move both positions.
- R12: `level` always equals the number of bytes held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; bytes are taken only while high |
| rxie | input | 1 | Receive interrupt enable |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | WIDTH | Received byte |
| cfg_we | input | 1 | Write strobe for the FIFO control register |
| cfg_wdata | input | 8 | Control data: bits 7:6 threshold code, bit 1 flush |
| rd_pop | input | 1 | Data register read; pops the oldest byte |
| rd_data | output | WIDTH | Oldest stored byte |
| level | output | CW | Number of bytes held |
| rx_full | output | 1 | Occupancy has reached the threshold |
| irq | output | 1 | Latched receive interrupt |
| irq_clr | input | 1 | Clears the latched interrupt |

## Verification
The bench goes after each threshold code exactly at its boundary, pushing one byte short of the threshold and then the byte that reaches it. A design with a mis-decoded selector would raise `rx_full` one step early or late. It fills the store past 16 and drains it. A design that still accepted bytes when full would overwrite the oldest byte, and the scoreboard would see wrong data. It pops an empty store and sends bytes while `rx_en` is low, where a faulty read position or gating would shift later data. A long streaming run crosses the wrap point several times. The bench also combines a push with a pop and a push with a flush in the same cycle, which exposes a count that drifts or a flush that loses priority.

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int DEPTH     = 16,
  parameter int WIDTH     = 8,
  parameter int TRIG0     = 1,
  parameter int TRIG1     = 4,
  parameter int TRIG2     = 8,
  parameter int TRIG3     = 14,
  parameter int FLUSH_BIT = 1,
  parameter int TRIG_LSB  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rx_en,
  input  logic                          rxie,
  input  logic                          in_valid,
  input  logic [WIDTH-1:0]              in_data,
  input  logic                          cfg_we,
  input  logic [7:0]                    cfg_wdata,
  input  logic                          rd_pop,
  output logic [WIDTH-1:0]              rd_data,
  output logic [$clog2(DEPTH+1)-1:0]    level,
  output logic                          rx_full,
  output logic                          irq,
  input  logic                          irq_clr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    head, tail;
  logic [CW-1:0]    cnt, cnt_n, trig;
  logic [1:0]       tsel;
  logic             flush, push, pop, hit;
  logic             unused_cfg;

  assign unused_cfg = ^cfg_wdata;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    case (tsel)
      2'd0:    trig = CW'(TRIG0);
      2'd1:    trig = CW'(TRIG1);
      2'd2:    trig = CW'(TRIG2);
      default: trig = CW'(TRIG3);
    endcase
  end

  assign flush = cfg_we & cfg_wdata[FLUSH_BIT];
  assign push  = in_valid & rx_en & (cnt < CW'(DEPTH)) & ~flush;
  assign pop   = rd_pop & (cnt != '0) & ~flush;

  always_comb begin
    cnt_n = cnt;
    if (flush)            cnt_n = '0;
    else if (push && !pop) cnt_n = cnt + CW'(1);
    else if (pop && !push) cnt_n = cnt - CW'(1);
  end

  assign hit = push & (cnt_n >= trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      cnt     <= '0;
      tsel    <= 2'd0;
      rx_full <= 1'b0;
      irq     <= 1'b0;
    end else begin
      cnt <= cnt_n;
      if (cfg_we) tsel <= cfg_wdata[TRIG_LSB +: 2];
      if (flush) begin
        head <= '0;
        tail <= '0;
      end else begin
        if (push) head <= wrap_inc(head);
        if (pop)  tail <= wrap_inc(tail);
      end
      if (flush)                      rx_full <= 1'b0;
      else if (hit)                   rx_full <= 1'b1;
      else if (pop && cnt_n < trig)   rx_full <= 1'b0;
      if (hit && rxie)  irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[head] <= in_data;
  end

  assign rd_data = mem[tail];
  assign level   = cnt;
endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
  parameter int DEPTH     = 16,
  parameter int CW        = 5,
  parameter int FLUSH_BIT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rxie,
  input logic          in_valid,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic          rd_pop,
  input logic [CW-1:0] level,
  input logic          rx_full,
  input logic          irq,
  input logic          irq_clr
);
  logic fl;
  assign fl = cfg_we & cfg_wdata[FLUSH_BIT];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)); // R12
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rx_en && level == CW'(DEPTH) && !rd_pop && !fl) |=> level == CW'(DEPTH)); // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && level == '0 && !in_valid && !cfg_we) |=> level == '0); // R10
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rd_pop && !cfg_we) |=> $stable(level)); // R9
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    fl |=> (level == '0 && !rx_full)); // R7
  AST_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rx_en && rd_pop && level != '0 && level != CW'(DEPTH) && !fl) |=> $stable(level)); // R11
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !rxie) |=> !irq); // R6
endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH), .CW(CW), .FLUSH_BIT(FLUSH_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxie(rxie), .in_valid(in_valid),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rd_pop(rd_pop), .level(level),
  .rx_full(rx_full), .irq(irq), .irq_clr(irq_clr)
);

// File: tb/test_rx_trig_fifo.sv
`timescale 1ns/1ps
module test_rx_trig_fifo;
  logic       clk = 0, rst_n = 0;
  logic       rx_en = 1, rxie = 1, in_valid = 0, cfg_we = 0, rd_pop = 0, irq_clr = 0;
  logic [7:0] in_data = 0, cfg_wdata = 0, rd_data;
  logic [4:0] level;
  logic       rx_full, irq;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] q[$];

  always #2.5 clk = ~clk;

  rx_trig_fifo i_rx_trig_fifo (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxie(rxie), .in_valid(in_valid),
    .in_data(in_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rd_pop(rd_pop),
    .rd_data(rd_data), .level(level), .rx_full(rx_full), .irq(irq), .irq_clr(irq_clr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each popped byte against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && rd_pop && !(cfg_we && cfg_wdata[1]) && q.size() > 0) begin
      chk(rd_data == q[0], "R2 R3 order", rd_data, q[0]);
      void'(q.pop_front());
    end
  end

  // driver: one cycle of stimulus, model update after the edge
  task automatic step(input bit v, input logic [7:0] b, input bit rd, input bit we, input logic [7:0] wd);
    int pre;
    @(negedge clk);
    pre = q.size();
    in_valid = v; in_data = b; rd_pop = rd; cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    if (we && wd[1]) q.delete();
    else if (v && rx_en && pre < 16) q.push_back(b);
    #1;
    in_valid = 0; rd_pop = 0; cfg_we = 0;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1;
    @(posedge clk); #1; irq_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(level == 0, "R1 level", level, 0);
    chk(rx_full == 0, "R1 rx_full", rx_full, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    rst_n = 1;

    step(1, 8'hA1, 0, 0, 0);
    chk(level == 1, "R12 level", level, 1);
    chk(rx_full == 1, "R1 R5 default threshold 1", rx_full, 1);
    chk(irq == 1, "R6 irq set", irq, 1);
    step(0, 0, 0, 0, 0);
    chk(irq == 1, "R6 irq held", irq, 1);
    clr_irq();
    chk(irq == 0, "R6 irq cleared", irq, 0);
    step(0, 0, 1, 0, 0);
    chk(level == 0 && rx_full == 0, "R5 pop below threshold", {level, rx_full}, 0);

    step(0, 0, 1, 0, 0);
    chk(level == 0, "R10 empty pop", level, 0);
    step(1, 8'hB0, 0, 0, 0);
    step(0, 0, 1, 0, 0);

    step(0, 0, 0, 1, 8'h40);
    for (int i = 0; i < 3; i++) step(1, 8'h10 + 8'(i), 0, 0, 0);
    chk(rx_full == 0, "R4 code1 below", rx_full, 0);
    step(1, 8'h13, 0, 0, 0);
    chk(rx_full == 1, "R4 code1 at 4", rx_full, 1);
    step(0, 0, 1, 0, 0);
    chk(rx_full == 0 && level == 3, "R5 drop below 4", {level, rx_full}, 6);
    step(0, 0, 0, 1, 8'h42);
    chk(level == 0 && rx_full == 0, "R7 flush", {level, rx_full}, 0);

    step(0, 0, 0, 1, 8'h80);
    for (int i = 0; i < 7; i++) step(1, 8'h20 + 8'(i), 0, 0, 0);
    chk(rx_full == 0, "R4 code2 below", rx_full, 0);
    step(1, 8'h27, 0, 0, 0);
    chk(rx_full == 1, "R4 code2 at 8", rx_full, 1);
    step(0, 0, 0, 1, 8'hC2);

    for (int i = 0; i < 13; i++) step(1, 8'h30 + 8'(i), 0, 0, 0);
    chk(rx_full == 0, "R4 code3 below", rx_full, 0);
    step(1, 8'h3D, 0, 0, 0);
    chk(rx_full == 1, "R4 code3 at 14", rx_full, 1);
    step(1, 8'h3E, 0, 0, 0);
    step(1, 8'h3F, 0, 0, 0);
    step(1, 8'hEE, 0, 0, 0);
    step(1, 8'hEF, 0, 0, 0);
    chk(level == 16, "R8 overflow dropped", level, 16);
    for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0);
    chk(level == 0, "R8 R3 drained", level, 0);

    step(0, 0, 0, 1, 8'h00);
    clr_irq();
    rxie = 0;
    step(1, 8'h55, 0, 0, 0);
    chk(rx_full == 1 && irq == 0, "R6 irq gated", {rx_full, irq}, 2);
    step(0, 0, 1, 0, 0);
    rxie = 1;

    rx_en = 0;
    step(1, 8'h66, 0, 0, 0);
    chk(level == 0, "R9 rx disabled", level, 0);
    rx_en = 1;

    step(1, 8'h71, 0, 0, 0);
    step(1, 8'h72, 1, 0, 0);
    chk(level == 1, "R11 push and pop", level, 1);
    step(0, 0, 1, 0, 0);

    step(1, 8'h73, 0, 1, 8'h02);
    chk(level == 0, "R7 flush beats push", level, 0);

    for (int i = 0; i < 40; i++) step(1, 8'h80 + 8'(i), q.size() >= 3, 0, 0);
    while (q.size() > 0) step(0, 0, 1, 0, 0);
    chk(level == 0, "R3 R12 stream drained", level, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule